// File: doc/BRIEF.md
# Adaptive Scan Shift Pacer

This block paces the shifting of a scan chain from a fast reference clock. It produces a one-cycle shift enable at one of four rates: every reference cycle, or every second, third or fourth cycle. The rate is picked from how quiet the chain currently is. A built-in chain of `N` scan flip-flops is shifted by that enable, and the serial stream can be observed at `scan_out_o`. An activity counter tracks how many adjacent bit pairs inside the chain hold equal values. It counts up when a quiet pair is shifted in and counts down when a quiet pair is shifted out. A larger count means fewer toggles per shift, so the block can afford a faster shift rate.

The external tester asserts `start_i` for one cycle together with a nonzero bit count on `length_i`. The block holds `busy_o` high while it shifts that many bits. It then pulses `done_o` for one cycle. The tester presents each serial bit on `scan_in_i` in every cycle in which `shift_en_o` is high.

Each rate change takes effect only when a shift pulse is issued, so a gap between two shifts is never cut short. The chain and the counter keep their contents from one run to the next. Only reset returns them to the all-transition starting state, in which the slowest rate is selected.

Top module: `adaptive_shift_pacer`

## Requirements
- R1: After synchronous reset, chain bit i holds i mod 2, so bit 0 is 0 and `scan_out_o` (the last bit, N-1) is 1 for even N. After reset `busy_o`, `done_o` and `shift_en_o` are 0, `nt_count_o` is 0 and `rate_idx_o` is 0, the slowest rate.
- R2: A cycle with `start_i`=1, `busy_o`=0 and `length_i`=L>0 makes `busy_o` high from the next cycle on. Exactly L shift pulses follow. In the cycle after the last pulse, `busy_o` is 0 and `done_o` is 1. `done_o` is 0 again in the cycle after that.
- R3: `start_i` has no effect while `busy_o` is high, and none when `length_i` is 0. No extra shifts occur, and a zero-length start raises neither `busy_o` nor `done_o`.
- R4: A shift whose input bit equals chain bit 0 (the bit shifted in just before it) is an entering non-transition, and adds 1 to `nt_count_o` in the next cycle.
- R5: A shift in which chain bits N-1 and N-2 are equal is a leaving non-transition, and subtracts 1. When both events occur in the same shift, the count is unchanged. The count never exceeds N-1.
- R6: `rate_idx_o` equals the lesser of 3 and `nt_count_o` divided by N/4 (integer division). Index k selects a divide ratio of 4-k.
- R7: The first shift pulse comes r cycles after the start cycle, where r is the ratio selected by the count at start. After every shift pulse, the next pulse comes r' cycles later, where r' is the ratio selected by the count that results from that shift.
- R8: On each shift the chain moves one place toward bit N-1, and the input bit enters at bit 0. `scan_out_o` always shows bit N-1, so an input bit reappears at the output after N shifts.
- R9: `nt_count_o` and the chain change only in cycles in which `shift_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a shift run (one-cycle request) |
| length_i | input | LEN_W | Number of bits to shift in the run |
| scan_in_i | input | 1 | Serial bit, taken when `shift_en_o` is high |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse after the last shift |
| shift_en_o | output | 1 | Shift pulse; the chain moves on this cycle |
| scan_out_o | output | 1 | Last bit of the scan chain |
| rate_idx_o | output | 2 | Selected rate index, 0 = slowest |
| nt_count_o | output | CNT_W | Non-transitions currently held in the chain |

## Verification
The two functions that can fall in the same shift are the increment for an entering non-transition and the decrement for a leaving one. A long run of constant zeros fills the chain with equal pairs and drives the count to its ceiling of N-1. Once the count is there, every further shift carries both events, and the count must then hold steady while the pace stays at one shift per cycle. An alternating stream that follows then removes pairs only at the output. The bench judges the resulting step-down by comparing the count, the rate index and every gap between pulses with a reference chain kept in the bench.

// File: rtl/asp_pkg.sv
package asp_pkg;

   localparam int NUM_RATES = 4;
   localparam int RATIO_W   = 3;

   typedef logic [1:0] rate_idx_t;

   // slowest index (0) maps to the largest divide ratio
   function automatic logic [RATIO_W-1:0] idx_to_ratio(input rate_idx_t idx);
      return RATIO_W'(NUM_RATES) - RATIO_W'(idx);
   endfunction

endpackage

// File: rtl/asp_nt_monitor.sv
module asp_nt_monitor #(
   parameter int N     = 16,
   parameter int CNT_W = $clog2(N) + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic             scan_out_o,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] next_count_o
);

   logic [N-1:0] chain;
   logic [N-1:0] rst_pat;
   logic         enter_nt;
   logic         leave_nt;

   // all-transition start pattern: bit i = i mod 2
   for (genvar i = 0; i < N; i++) begin : g_pat
      assign rst_pat[i] = 1'(i % 2);
   end

   assign enter_nt = (bit_i == chain[0]);
   assign leave_nt = (chain[N-1] == chain[N-2]);

   always_comb begin
      next_count_o = count_o;
      if (shift_i) begin
         unique case ({enter_nt, leave_nt})
            2'b10:   next_count_o = count_o + 1'b1;
            2'b01:   next_count_o = count_o - 1'b1;
            default: next_count_o = count_o;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chain   <= rst_pat;
         count_o <= '0;
      end else if (shift_i) begin
         chain   <= {chain[N-2:0], bit_i};
         count_o <= next_count_o;
      end
   end

   assign scan_out_o = chain[N-1];

   // R5: the count can never exceed the number of adjacent pairs
   p_count_max_r5: assert property (@(posedge clk) disable iff (rst)
      count_o <= CNT_W'(N - 1));

   // R5: simultaneous entering and leaving events cancel
   p_both_cancel_r5: assert property (@(posedge clk) disable iff (rst)
      (shift_i && enter_nt && leave_nt) |=> $stable(count_o));

   // R4: one shift moves the count by at most one
   p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
      shift_i |=> (count_o == $past(count_o)) ||
                  (count_o == $past(count_o) + 1'b1) ||
                  (count_o == $past(count_o) - 1'b1));

   // R9: no shift, no change in the count
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !shift_i |=> $stable(count_o));

   // R8: the output takes the bit that sat one place before it
   p_advance_r8: assert property (@(posedge clk) disable iff (rst)
      shift_i |=> scan_out_o == $past(chain[N-2]));

endmodule

// File: rtl/asp_rate_sel.sv
module asp_rate_sel
   import asp_pkg::*;
#(
   parameter int N     = 16,
   parameter int CNT_W = $clog2(N) + 1
) (
   input  logic [CNT_W-1:0]   count_i,
   output rate_idx_t          idx_o,
   output logic [RATIO_W-1:0] ratio_o
);

   localparam int QUARTER = N / 4;
   localparam int Q_SH    = $clog2(QUARTER);

   if ((QUARTER & (QUARTER - 1)) == 0) begin : g_shift
      logic [CNT_W-1:0] steps;
      assign steps = count_i >> Q_SH;
      assign idx_o = (steps > CNT_W'(3)) ? rate_idx_t'(3) : rate_idx_t'(steps);
   end else begin : g_compare
      always_comb begin
         if (count_i >= CNT_W'(3 * QUARTER))      idx_o = 2'd3;
         else if (count_i >= CNT_W'(2 * QUARTER)) idx_o = 2'd2;
         else if (count_i >= CNT_W'(QUARTER))     idx_o = 2'd1;
         else                                     idx_o = 2'd0;
      end
   end

   assign ratio_o = idx_to_ratio(idx_o);

   // R6: the ratio always lies within the four legal divisors
   always_comb begin
      p_ratio_range_r6: assert (ratio_o >= 3'd1 && ratio_o <= 3'd4);
   end

endmodule

// File: rtl/asp_pace_div.sv
module asp_pace_div
   import asp_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_i,
   input  logic [LEN_W-1:0]   length_i,
   input  logic [RATIO_W-1:0] ratio_now_i,
   input  logic [RATIO_W-1:0] ratio_next_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               shift_o
);

   logic [1:0]       phase;
   logic [LEN_W-1:0] remaining;

   assign shift_o = busy_o && (phase == 2'd0);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
         phase     <= 2'd0;
         remaining <= '0;
      end else begin
         done_o <= 1'b0;
         if (!busy_o) begin
            if (start_i && (length_i != '0)) begin
               busy_o    <= 1'b1;
               remaining <= length_i;
               phase     <= 2'(ratio_now_i - 3'd1);
            end
         end else if (shift_o) begin
            if (remaining == LEN_W'(1)) begin
               busy_o    <= 1'b0;
               done_o    <= 1'b1;
               phase     <= 2'd0;
               remaining <= '0;
            end else begin
               remaining <= remaining - 1'b1;
               phase     <= 2'(ratio_next_i - 3'd1);
            end
         end else begin
            phase <= phase - 2'd1;
         end
      end
   end

   // R2: pulses only inside a run
   p_shift_in_run_r2: assert property (@(posedge clk) disable iff (rst)
      shift_o |-> busy_o);

   // R2: done is a single-cycle pulse outside a run
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o);

   // R3: a request during a run leaves the bit budget untouched
   p_run_budget_r3: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !shift_o) |=> remaining == $past(remaining));

   // R7: a slower ratio leaves a gap after the pulse
   p_gap_r7: assert property (@(posedge clk) disable iff (rst)
      (shift_o && remaining != LEN_W'(1) && ratio_next_i > 3'd1) |=> !shift_o);

endmodule

// File: rtl/adaptive_shift_pacer.sv
module adaptive_shift_pacer
   import asp_pkg::*;
#(
   parameter int N     = 16,
   parameter int LEN_W = 16,
   localparam int CNT_W = $clog2(N) + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [LEN_W-1:0] length_i,
   input  logic             scan_in_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             shift_en_o,
   output logic             scan_out_o,
   output logic [1:0]       rate_idx_o,
   output logic [CNT_W-1:0] nt_count_o
);

   if (N < 8 || (N % 4) != 0) begin : g_bad_n
      $error("adaptive_shift_pacer: N must be a multiple of 4 and at least 8");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("adaptive_shift_pacer: LEN_W must be positive");
   end

   logic [CNT_W-1:0]   next_count;
   logic [RATIO_W-1:0] ratio_now;
   logic [RATIO_W-1:0] ratio_next;
   rate_idx_t          idx_now;
   rate_idx_t          idx_next;

   asp_nt_monitor #(.N(N), .CNT_W(CNT_W)) u_mon (
      .clk          (clk),
      .rst          (rst),
      .shift_i      (shift_en_o),
      .bit_i        (scan_in_i),
      .scan_out_o   (scan_out_o),
      .count_o      (nt_count_o),
      .next_count_o (next_count)
   );

   asp_rate_sel #(.N(N), .CNT_W(CNT_W)) u_sel_now (
      .count_i (nt_count_o),
      .idx_o   (idx_now),
      .ratio_o (ratio_now)
   );

   asp_rate_sel #(.N(N), .CNT_W(CNT_W)) u_sel_next (
      .count_i (next_count),
      .idx_o   (idx_next),
      .ratio_o (ratio_next)
   );

   asp_pace_div #(.LEN_W(LEN_W)) u_div (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .length_i     (length_i),
      .ratio_now_i  (ratio_now),
      .ratio_next_i (ratio_next),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .shift_o      (shift_en_o)
   );

   assign rate_idx_o = idx_now;

   // R1: leaving reset selects the slowest rate
   p_reset_slow_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rate_idx_o == 2'd0 && !busy_o));

   // R2: an accepted request starts a run
   p_accept_r2: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && start_i && length_i != '0) |=> busy_o);

   // R3: a zero-length request is ignored
   p_zero_len_r3: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && length_i == '0) |=> !busy_o);

   // R7: the rate index moves by at most one step per shift
   p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
      shift_en_o |-> (idx_next == idx_now || idx_next == idx_now + 2'd1 ||
                      idx_next == idx_now - 2'd1));

endmodule

// File: tb/sim_adaptive_shift_pacer.sv
module sim_adaptive_shift_pacer;

   localparam int N     = 16;
   localparam int LEN_W = 16;
   localparam int CNT_W = $clog2(N) + 1;
   localparam int Q     = N / 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start_i = 1'b0;
   logic [LEN_W-1:0] length_i = '0;
   logic             scan_in_i = 1'b0;
   logic             busy_o, done_o, shift_en_o, scan_out_o;
   logic [1:0]       rate_idx_o;
   logic [CNT_W-1:0] nt_count_o;

   int n_checks = 0;
   int n_fail   = 0;

   logic       m_chain [N];
   int         m_cnt;
   logic [7:0] lfsr = 8'hA5;

   always #10 clk = ~clk;

   adaptive_shift_pacer #(.N(N), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .length_i(length_i),
      .scan_in_i(scan_in_i), .busy_o(busy_o), .done_o(done_o),
      .shift_en_o(shift_en_o), .scan_out_o(scan_out_o),
      .rate_idx_o(rate_idx_o), .nt_count_o(nt_count_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int idx_of(input int c);
      return (c / Q > 3) ? 3 : c / Q;
   endfunction

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // model of one shift, written from R4, R5 and R8
   task automatic model_shift(input logic b, output bit left_pair);
      bit ent;
      ent       = (b == m_chain[0]);
      left_pair = (m_chain[N-1] == m_chain[N-2]);
      m_cnt     = m_cnt + int'(ent) - int'(left_pair);
      for (int i = N - 1; i > 0; i--) m_chain[i] = m_chain[i-1];
      m_chain[0] = b;
   endtask

   function automatic logic gen_bit(input int mode, input int k);
      case (mode)
         0:       return 1'b0;
         1:       return ~m_chain[0];
         2:       return lfsr[0];
         default: return 1'(k >> 1);
      endcase
   endfunction

   task automatic test_reset();
      chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
      chk(done_o == 1'b0, "R1 done", done_o, 0);
      chk(shift_en_o == 1'b0, "R1 shift_en", shift_en_o, 0);
      chk(nt_count_o == '0, "R1 count", nt_count_o, 0);
      chk(rate_idx_o == 2'd0, "R1 rate", rate_idx_o, 0);
      chk(scan_out_o == 1'b1, "R1 scan_out", scan_out_o, 1);
   endtask

   task automatic test_zero_length();
      start_i = 1'b1; length_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b0, "R3 zero length busy", busy_o, 0);
      @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R3 zero length done", done_o, 0);
      chk(nt_count_o == CNT_W'(m_cnt), "R3 zero length count", nt_count_o, m_cnt);
   endtask

   // one run of len shifts with bits from generator mode
   task automatic run_scan(input int len, input int mode, input bit poke_start);
      int  shifts = 0;
      int  gap    = 0;
      int  total  = 0;
      int  r;
      bit  prev_shift = 0;
      bit  prev_left  = 0;
      bit  left;
      logic b;
      start_i = 1'b1; length_i = LEN_W'(len);
      r = 4 - idx_of(m_cnt);
      @(negedge clk);
      start_i = 1'b0;
      gap = 1;
      while (shifts < len) begin
         chk(busy_o == 1'b1, "R2 busy during run", busy_o, 1);
         if (prev_left)
            chk(nt_count_o == CNT_W'(m_cnt), "R5 count", nt_count_o, m_cnt);
         else if (prev_shift)
            chk(nt_count_o == CNT_W'(m_cnt), "R4 count", nt_count_o, m_cnt);
         else
            chk(nt_count_o == CNT_W'(m_cnt), "R9 count held", nt_count_o, m_cnt);
         chk(rate_idx_o == 2'(idx_of(m_cnt)), "R6 rate index", rate_idx_o, idx_of(m_cnt));
         prev_shift = 0; prev_left = 0;
         if (shift_en_o) begin
            chk(gap == r, "R7 shift spacing", gap, r);
            chk(scan_out_o == m_chain[N-1], "R8 scan out", scan_out_o, m_chain[N-1]);
            b = gen_bit(mode, shifts);
            scan_in_i = b;
            model_shift(b, left);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            shifts++;
            r = 4 - idx_of(m_cnt);
            gap = 0;
            prev_shift = 1;
            prev_left  = left;
         end
         start_i  = (poke_start && total == 5);
         length_i = LEN_W'(3);
         @(negedge clk);
         start_i = 1'b0;
         gap++; total++;
      end
      chk(done_o == 1'b1, "R2 done after last shift", done_o, 1);
      chk(busy_o == 1'b0, "R2 busy cleared", busy_o, 0);
      chk(shift_en_o == 1'b0, "R3 no extra shift", shift_en_o, 0);
      chk(nt_count_o == CNT_W'(m_cnt), "R4 final count", nt_count_o, m_cnt);
      @(negedge clk);
      chk(done_o == 1'b0, "R2 done single cycle", done_o, 0);
      chk(shift_en_o == 1'b0 && busy_o == 1'b0, "R3 run not restarted", busy_o, 0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) m_chain[i] = 1'(i % 2);
      m_cnt = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      test_reset();
      test_zero_length();
      run_scan(40, 0, 1'b0);   // count to ceiling, then both events each shift
      chk(nt_count_o == CNT_W'(N - 1), "R5 ceiling reached", nt_count_o, N - 1);
      chk(rate_idx_o == 2'd3, "R6 fastest rate", rate_idx_o, 3);
      run_scan(24, 1, 1'b0);   // alternating drains pairs at the output
      chk(rate_idx_o == 2'd0, "R6 back to slowest", rate_idx_o, 0);
      run_scan(60, 2, 1'b1);   // pseudo-random with a start request mid-run
      run_scan(20, 3, 1'b0);   // pairs 0011
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      report();
      $finish;
   end

endmodule